// File: doc/BRIEF.md
# Keyed watchdog timer

This block is a watchdog counter driven by a slow tick enable (nominally a 32 kHz strobe). Software sets it up through a flat 32-bit register port. Every register that can change behaviour is guarded by a key. A write whose key field does not match is dropped whole. A running watchdog must be restarted with a fixed magic word before its count runs out.

There are two ways to run it. In single mode, the first expiry fires the reset output. In dual mode with the interrupt enabled, the first expiry raises an interrupt and reloads the count. A second expiry without a restart then fires the reset. Programming half of the wanted timeout therefore gives an interrupt at the midpoint and a reset at the full time. A software-reset word fires the reset output at once. A separate keyed register drives a vector of individual reset lines.

Each reset episode holds the output for a fixed number of ticks, with a programmable polarity.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is released, all three readable registers read zero, `irq_out` and `line_rst` are 0, and `rst_out` is 1 (inactive, because the polarity bit is 0).
- R2: Offset 0x00 is the mode register. Its bits are: bit 0 run, bit 1 polarity (1 = active-high reset), bit 2 expiry-reset enable, bit 3 interrupt enable, bit 4 auto-reload on length write, bit 6 dual mode. A write is taken only when bits 31:24 equal 0x22. A read returns those bits and zero elsewhere.
- R3: Offset 0x04 is the length register. The length is held in bits 15:5. A write is taken only when bits 4:0 equal 0x08. A read returns the length in bits 15:5 and zero elsewhere.
- R4: With the run bit set, expiry happens on the tick that completes length × UNIT_TICKS ticks since the last reload. In single mode, expiry starts a reset episode only if bit 2 is set.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the count. Any other value has no effect. A restart and a tick in the same cycle give a reload, not an expiry.
- R6: A length write does not change the running count unless bit 4 is set, in which case the count reloads from the new length.
- R7: In dual mode with bit 3 set, the first expiry raises `irq_out` and reloads. The next expiry starts a reset episode and drops `irq_out`.
- R8: A restart, or clearing the run bit, drops `irq_out` and returns dual mode to its first stage.
- R9: Writing exactly 0x1209 to offset 0x14 starts a reset episode in the next cycle, whatever the mode bits. Any other value has no effect.
- R10: A reset episode holds `rst_out` active for HOLD_TICKS ticks and then releases it. Active means the level of the polarity bit.
- R11: Offset 0x18 drives `line_rst` from the low bits of the written word when bits 31:24 equal 0x88. A read returns the current line states.
- R12: While the run bit is clear the count is frozen. Setting the run bit reloads the count from the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count strobe (32 kHz rate) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data including key fields |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_out | output | 1 | Reset output, polarity from mode bit 1 |
| irq_out | output | 1 | First-stage interrupt in dual mode |
| line_rst | output | NLINES | Individually driven reset lines |

## Verification
Two functions can fall in the same cycle: a restart write and the tick that would expire the count. The bench runs the count down to its last tick, then issues the restart write with `tick` high in the same cycle. It then expects a full length of quiet ticks before reset, since a lost restart would show up as an immediate reset. Disabling the run bit while dual mode has an interrupt pending is also checked. After re-enabling, the next expiry must bring an interrupt again, not a reset.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512,
  parameter int HOLD_TICKS = 16,
  parameter int NLINES     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rst_out,
  output logic              irq_out,
  output logic [NLINES-1:0] line_rst
);
  localparam int CNT_W  = LEN_W + $clog2(UNIT_TICKS) + 1;
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SWR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(8'h18);

  logic [6:0]        mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stage_q, irq_q;
  logic [HOLD_W-1:0] hold_q;
  logic [NLINES-1:0] lines_q;

  wire wr_mode = reg_wr && reg_addr == A_MODE && reg_wdata[31:24] == 8'h22;
  wire wr_len  = reg_wr && reg_addr == A_LEN  && reg_wdata[4:0] == 5'h08;
  wire wr_kick = reg_wr && reg_addr == A_KICK && reg_wdata == 32'h0000_1971;
  wire wr_swr  = reg_wr && reg_addr == A_SWR  && reg_wdata == 32'h0000_1209;
  wire wr_sys  = reg_wr && reg_addr == A_SYS  && reg_wdata[31:24] == 8'h88;

  wire [6:0]       mode_d = wr_mode ? (reg_wdata[6:0] & 7'h5F) : mode_q;
  wire [LEN_W-1:0] len_d  = wr_len ? reg_wdata[5 +: LEN_W] : len_q;
  wire [CNT_W-1:0] reload = CNT_W'(len_d) * CNT_W'(UNIT_TICKS);

  wire run        = mode_d[0];
  wire start      = mode_d[0] & ~mode_q[0];
  wire reload_now = wr_kick | start | (wr_len & mode_q[4]);
  wire expire     = run & tick & ~reload_now & (cnt_q <= CNT_W'(1));
  wire to_irq     = expire & mode_q[6] & mode_q[3] & ~stage_q;
  wire to_rst     = expire & ~to_irq;
  wire hold_on    = hold_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
      hold_q  <= '0;
      lines_q <= '0;
    end else begin
      mode_q <= mode_d;
      len_q  <= len_d;
      if (wr_sys) lines_q <= reg_wdata[NLINES-1:0];

      if (!run) begin
        stage_q <= 1'b0;
        irq_q   <= 1'b0;
      end else if (reload_now) begin
        cnt_q   <= reload;
        stage_q <= 1'b0;
        irq_q   <= 1'b0;
      end else if (tick) begin
        if (expire) begin
          cnt_q   <= reload;
          stage_q <= to_irq;
          irq_q   <= to_irq;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end

      if (wr_swr || (to_rst && mode_q[2]))
        hold_q <= HOLD_W'(HOLD_TICKS);
      else if (tick && hold_on)
        hold_q <= hold_q - HOLD_W'(1);
    end
  end

  assign rst_out  = mode_q[1] ? hold_on : ~hold_on;
  assign irq_out  = irq_q;
  assign line_rst = lines_q;

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {25'b0, mode_q};
      A_LEN:   reg_rdata = 32'(len_q) << 5;
      A_SYS:   reg_rdata = 32'(lines_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module keyed_watchdog_chk #(
  parameter int ADDR_W = 8,
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              rst_out,
  input logic              irq_out,
  input logic [NLINES-1:0] line_rst,
  input logic [6:0]        mode_q,
  input logic              hold_on
);
  assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(reg_wr && reg_addr == ADDR_W'(8'h00) && reg_wdata[31:24] == 8'h22));

  assert_irq_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(mode_q[6] && mode_q[3]));

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h08) && reg_wdata == 32'h0000_1971) |=> !irq_out);

  assert_off_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |-> !irq_out);

  assert_swreset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h14) && reg_wdata == 32'h0000_1209) |=> (rst_out == mode_q[1]));

  assert_release_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_on) |-> $past(tick));

  assert_lines_key_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_rst) |-> $past(reg_wr && reg_addr == ADDR_W'(8'h18) && reg_wdata[31:24] == 8'h88));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rst_out(rst_out), .irq_out(irq_out), .line_rst(line_rst),
  .mode_q(mode_q), .hold_on(hold_on)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam logic [31:0] LEN3 = 32'h0000_0068;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rst_out, irq_out;
  logic [NL-1:0] line_rst;

  int checks = 0, errors = 0;
  logic [6:0]  m_mode = '0;
  logic [10:0] m_len = '0;
  logic [15:0] m_lines = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.UNIT_TICKS(4), .NLINES(NL)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_out(rst_out),
    .irq_out(irq_out), .line_rst(line_rst)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return {25'b0, m_mode};
      8'h04:   return {16'b0, m_len, 5'b0};
      8'h18:   return {16'b0, m_lines};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h00 && d[31:24] == 8'h22) m_mode = d[6:0] & 7'h5F;
    if (a == 8'h04 && d[4:0] == 5'h08) m_len = d[15:5];
    if (a == 8'h18 && d[31:24] == 8'h88) m_lines = d[15:0];
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h00, v); check(v, 0, "R1 mode");
    rd(8'h04, v); check(v, 0, "R1 length");
    rd(8'h18, v); check(v, 0, "R1 lines");
    check(rst_out, 1, "R1 rst_out"); check(irq_out, 0, "R1 irq_out");
    check(line_rst, 0, "R1 line_rst");

    for (int i = 0; i < 48; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int s;
      s = $urandom % 3;
      a = (s == 0) ? 8'h00 : (s == 1) ? 8'h04 : 8'h18;
      d = $urandom;
      if ($urandom % 2) begin
        if (a == 8'h00) d[31:24] = 8'h22;
        else if (a == 8'h04) d[4:0] = 5'h08;
        else d[31:24] = 8'h88;
      end
      model_write(a, d);
      wr(a, d);
      rd(a, v);
      check(v, exp_read(a), (a == 8'h00) ? "R2 keyed mode" : (a == 8'h04) ? "R3 keyed length" : "R11 keyed lines");
      check(line_rst, m_lines, "R11 line_rst");
    end

    wr(8'h00, 32'h2200_0000); wr(8'h18, 32'h8800_0000); wr(8'h04, LEN3);

    // R4 single-mode expiry and R10 hold
    wr(8'h00, 32'h2200_0005);
    tk(11); check(rst_out, 1, "R4 before expiry");
    tk(1);  check(rst_out, 0, "R4 at expiry");
    wr(8'h00, 32'h2200_0004);
    tk(15); check(rst_out, 0, "R10 still held");
    tk(1);  check(rst_out, 1, "R10 released");

    // R4 expiry without reset enable
    wr(8'h00, 32'h2200_0001);
    tk(32); check(rst_out, 1, "R4 no reset when bit2 clear");
    wr(8'h00, 32'h2200_0000);

    // R5 restart
    wr(8'h00, 32'h2200_0005);
    tk(10); wr(8'h08, 32'h1971);
    tk(11); check(rst_out, 1, "R5 restart reloads");
    tk(1);  check(rst_out, 0, "R5 expiry after restart");
    wr(8'h00, 32'h2200_0004); tk(16);

    wr(8'h00, 32'h2200_0005);
    tk(10); wr(8'h08, 32'h1970);
    tk(2);  check(rst_out, 0, "R5 wrong restart ignored");
    wr(8'h00, 32'h2200_0004); tk(16);

    // R5 restart in same cycle as expiring tick
    wr(8'h00, 32'h2200_0005);
    tk(11); wr(8'h08, 32'h1971, 1'b1);
    check(rst_out, 1, "R5 same-cycle restart wins");
    tk(11); check(rst_out, 1, "R5 full length after same-cycle restart");
    tk(1);  check(rst_out, 0, "R5 expiry after same-cycle restart");
    wr(8'h00, 32'h2200_0004); tk(16);

    // R6 length writes
    wr(8'h00, 32'h2200_0005);
    tk(5); wr(8'h04, 32'h0000_0148);
    tk(6); check(rst_out, 1, "R6 count unchanged by length write");
    tk(1); check(rst_out, 0, "R6 expiry at old length");
    wr(8'h00, 32'h2200_0004); tk(16); wr(8'h04, LEN3);

    wr(8'h00, 32'h2200_0015);
    tk(5); wr(8'h04, 32'h0000_0028);
    tk(3); check(rst_out, 1, "R6 auto reload not yet expired");
    tk(1); check(rst_out, 0, "R6 auto reload expiry");
    wr(8'h00, 32'h2200_0004); tk(16); wr(8'h04, LEN3);

    // R7 dual mode
    wr(8'h00, 32'h2200_004D);
    tk(12); check(irq_out, 1, "R7 first stage irq"); check(rst_out, 1, "R7 no reset at first stage");
    tk(11); check(rst_out, 1, "R7 second stage pending");
    tk(1);  check(rst_out, 0, "R7 second stage reset"); check(irq_out, 0, "R7 irq dropped");
    wr(8'h00, 32'h2200_0004); tk(16);

    // R8 clearing the stage
    wr(8'h00, 32'h2200_004D);
    tk(12); check(irq_out, 1, "R8 irq raised");
    wr(8'h08, 32'h1971); check(irq_out, 0, "R8 restart drops irq");
    tk(12); check(irq_out, 1, "R8 stage reset by restart"); check(rst_out, 1, "R8 no reset after restart");
    wr(8'h00, 32'h2200_004C); check(irq_out, 0, "R8 disable drops irq");
    wr(8'h00, 32'h2200_004D);
    tk(12); check(irq_out, 1, "R8 stage reset by disable"); check(rst_out, 1, "R8 no reset after disable");
    wr(8'h00, 32'h2200_0000);

    // R12 frozen while disabled, reload on enable
    wr(8'h00, 32'h2200_0005);
    tk(6); wr(8'h00, 32'h2200_0004);
    tk(30); check(rst_out, 1, "R12 frozen while off");
    wr(8'h00, 32'h2200_0005);
    tk(11); check(rst_out, 1, "R12 reloaded on enable");
    tk(1);  check(rst_out, 0, "R12 expiry after enable");
    wr(8'h00, 32'h2200_0004); tk(16);

    // R9 software reset, R10 polarity
    wr(8'h00, 32'h2200_0002);
    check(rst_out, 0, "R10 active-high idle level");
    wr(8'h14, 32'h1208); check(rst_out, 0, "R9 wrong word ignored");
    wr(8'h14, 32'h1209); check(rst_out, 1, "R9 software reset");
    tk(15); check(rst_out, 1, "R10 high hold");
    tk(1);  check(rst_out, 0, "R10 high release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule